// File: doc/BRIEF.md
# Strobed Latched Byte Port

This block is a byte-wide input/output port for a small processor bus, modelled on a system clock. An 8-bit value is captured in a level-sensitive data latch and driven onto a data bus whose output stage is represented by a data vector plus a single output-enable. A mode input decides two things. It selects what opens the latch: the port-select condition or an external strobe. It also decides when the bus drives: always, or only while the port is selected.

A service-request flag is raised by each falling edge of the strobe and pulls an active-low interrupt line. Selecting the port, or holding the active-low clear input low, drops the flag. The interrupt line is also held low for as long as the port is selected. All bus-side inputs are asynchronous to the system clock. Each one passes through a synchronizer of configurable depth before any decision is made, so every output reacts a fixed number of clocks after its inputs settle.

Top module: `strobe_io_port`

## Requirements
- R1: The port counts as selected only while `sel_lo_n` is 0 and `sel_hi` is 1. The other three combinations leave it unselected.
- R2: While `mode` is 1, `bus_oe` is 1 and the latch opens when the port is selected.
- R3: While `mode` is 0, `bus_oe` equals the selected condition and the latch opens while `stb` is 1.
- R4: While open, the latch copies `din` onto `dout`. Once it closes, it keeps the last copied value, whatever `din` does afterwards.
- R5: A 0 on `clr_n` forces the latch contents to zero only while the latch is closed. While the latch is open, `clr_n` has no effect.
- R6: A 1-to-0 transition of `stb` sets the service request, which drives `irq_n` to 0. A 0-to-1 transition sets nothing.
- R7: The service request is cleared while the port is selected or while `clr_n` is 0. Either condition wins over a strobe fall seen in the same clock.
- R8: `irq_n` is 0 exactly when a service request is pending or the port is selected, and 1 otherwise.
- R9: After `rst_n` is released, the latch holds zero, no request is pending, `irq_n` is 1, and `bus_oe` is 0 while the inputs stay idle.
- R10: A change on any bus-side input shows at the outputs within `SYNC_STAGES + 1` clocks and not before `SYNC_STAGES` clocks. With the default of 2 stages, the bench samples outputs 4 clocks after each change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| din | input | W | Data presented to the latch |
| sel_lo_n | input | 1 | Select input that must be low to select the port |
| sel_hi | input | 1 | Select input that must be high to select the port |
| mode | input | 1 | 1: select opens latch, bus always driven; 0: strobe opens latch, select drives bus |
| stb | input | 1 | Strobe: latch clock in mode 0, falling edge raises a service request |
| clr_n | input | 1 | Active-low clear for latch (when closed) and service request |
| dout | output | W | Latch contents |
| bus_oe | output | 1 | Output enable; when 0 the bus is to be read as high impedance |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions work on the synchronized copies of the inputs. They take for granted that every bus-side input is steady long enough to pass through the synchronizer as a single coherent change, and that a strobe pulse lasts at least two clocks, so that its falling edge is a real event. The bench drives every input group at once on a falling clock edge. It holds that combination for four clocks before it samples and before it applies the next one, so each pulse and each level is seen whole. Random combinations are weighted so that `clr_n` is mostly high. This lets latched data and pending requests survive across several steps, and it also produces strobe falls that coincide with a select or a clear.

// File: rtl/sio_pkg.sv
package sio_pkg;

   // Bus-side control inputs gathered as one synchronized word.
   typedef struct packed {
      logic sel_lo_n;
      logic sel_hi;
      logic mode;
      logic stb;
      logic clr_n;
   } sio_ctrl_t;

   localparam int CTRL_W = $bits(sio_ctrl_t);

   // Idle values: unselected, strobe low, clear released.
   localparam sio_ctrl_t CTRL_IDLE = '{sel_lo_n: 1'b1, sel_hi: 1'b0,
                                       mode: 1'b0, stb: 1'b0, clr_n: 1'b1};

   function automatic logic port_selected(input sio_ctrl_t c);
      return (~c.sel_lo_n) & c.sel_hi;
   endfunction

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sio_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("sio_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/sio_latch.sv
module sio_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         open_i,
   input  logic         clr_n_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   // Open latch tracks data and masks the clear; closed latch obeys clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o <= '0;
      else if (open_i)   q_o <= d_i;
      else if (!clr_n_i) q_o <= '0;
   end

endmodule

// File: rtl/sio_srq.sv
module sio_srq (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_i,
   input  logic sel_i,
   input  logic clr_n_i,
   output logic fall_o,
   output logic srq_o
);

   logic stb_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_d <= 1'b0;
      else        stb_d <= stb_i;
   end

   assign fall_o = stb_d & ~stb_i;

   // Select and clear dominate a same-cycle strobe fall.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   srq_o <= 1'b0;
      else if (sel_i || !clr_n_i)   srq_o <= 1'b0;
      else if (fall_o)              srq_o <= 1'b1;
   end

endmodule

// File: rtl/strobe_io_port.sv
module strobe_io_port #(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit DIN_SYNC    = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   input  logic         sel_lo_n,
   input  logic         sel_hi,
   input  logic         mode,
   input  logic         stb,
   input  logic         clr_n,
   output logic [W-1:0] dout,
   output logic         bus_oe,
   output logic         irq_n
);
   import sio_pkg::*;

   if (W < 1) begin : g_bad_w
      $error("strobe_io_port: W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("strobe_io_port: SYNC_STAGES must be at least 2");
   end

   sio_ctrl_t    ctrl_raw, ctrl_q;
   logic [W-1:0] din_q;
   logic         sel_q, mode_q, clr_q, lclk, stb_fall, srq;
   logic [W-1:0] latch_q;

   assign ctrl_raw = '{sel_lo_n: sel_lo_n, sel_hi: sel_hi, mode: mode,
                       stb: stb, clr_n: clr_n};

   sio_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) i_ctrl_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctrl_raw),
      .q     (ctrl_q)
   );

   // Data path either aligned with the controls or taken as already stable.
   if (DIN_SYNC) begin : g_din_sync
      sio_sync #(.W(W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_din_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (din),
         .q     (din_q)
      );
   end else begin : g_din_direct
      assign din_q = din;
   end

   assign sel_q  = port_selected(ctrl_q);
   assign mode_q = ctrl_q.mode;
   assign clr_q  = ctrl_q.clr_n;
   assign lclk   = mode_q ? sel_q : ctrl_q.stb;

   sio_latch #(.W(W)) i_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .open_i  (lclk),
      .clr_n_i (clr_q),
      .d_i     (din_q),
      .q_o     (latch_q)
   );

   sio_srq i_srq (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb_i   (ctrl_q.stb),
      .sel_i   (sel_q),
      .clr_n_i (clr_q),
      .fall_o  (stb_fall),
      .srq_o   (srq)
   );

   assign dout   = latch_q;
   assign bus_oe = mode_q | sel_q;
   assign irq_n  = ~(srq | sel_q);

endmodule

// File: rtl/sio_port_checker.sv
module sio_port_checker #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         sel_q,
   input logic         mode_q,
   input logic         clr_q,
   input logic         lclk,
   input logic         stb_fall,
   input logic         srq,
   input logic [W-1:0] din_q,
   input logic [W-1:0] latch_q,
   input logic         bus_oe,
   input logic         irq_n
);

   p_mode_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q |-> bus_oe);

   p_idle_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && !sel_q) |-> !bus_oe);

   p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lclk |=> (latch_q == $past(din_q)));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!lclk && clr_q) |=> $stable(latch_q));

   p_clear_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!lclk && !clr_q) |=> (latch_q == '0));

   p_strobe_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_fall && !sel_q && clr_q) |=> srq);

   p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q || !clr_q) |=> !srq);

   p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !sel_q) |-> srq);

   p_irq_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
      srq |-> !irq_n);

endmodule

bind strobe_io_port sio_port_checker #(.W(W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_q    (sel_q),
   .mode_q   (mode_q),
   .clr_q    (clr_q),
   .lclk     (lclk),
   .stb_fall (stb_fall),
   .srq      (srq),
   .din_q    (din_q),
   .latch_q  (latch_q),
   .bus_oe   (bus_oe),
   .irq_n    (irq_n)
);

// File: tb/test_strobe_io_port.sv
module test_strobe_io_port;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] din = '0;
   logic         sel_lo_n = 1'b1, sel_hi = 1'b0, mode = 1'b0, stb = 1'b0, clr_n = 1'b1;
   logic [W-1:0] dout;
   logic         bus_oe, irq_n;
   wire  [W-1:0] bus = bus_oe ? dout : 'z;

   int checks = 0;
   int errors = 0;

   // Reference state
   logic [W-1:0] m_q = '0;
   logic         m_srq = 1'b0;
   logic         m_stb = 1'b0;

   always #2 clk = ~clk;

   strobe_io_port #(.W(W)) i_strobe_io_port (
      .clk(clk), .rst_n(rst_n), .din(din), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
      .mode(mode), .stb(stb), .clr_n(clr_n), .dout(dout), .bus_oe(bus_oe), .irq_n(irq_n)
   );

   function automatic logic f_sel(input logic a, input logic b);
      return (!a) && b;
   endfunction

   function automatic logic [W-1:0] f_bus(input logic md, input logic s, input logic [W-1:0] q);
      return (md || s) ? q : 'z;
   endfunction

   task automatic chk_bus(input string req);
      logic [W-1:0] e;
      e = f_bus(mode, f_sel(sel_lo_n, sel_hi), m_q);
      checks++;
      if (bus !== e) begin
         errors++;
         $display("FAIL %s bus actual %b expected %b", req, bus, e);
      end
   endtask

   task automatic chk_irq(input string req);
      logic e;
      e = !(m_srq || f_sel(sel_lo_n, sel_hi));
      checks++;
      if (irq_n !== e) begin
         errors++;
         $display("FAIL %s irq_n actual %b expected %b", req, irq_n, e);
      end
   endtask

   // Drive one settled input combination, advance the reference, sample late.
   task automatic step(input logic a, input logic b, input logic md, input logic s,
                       input logic cl, input logic [W-1:0] d, input string req);
      logic sel, open;
      @(negedge clk);
      sel_lo_n = a; sel_hi = b; mode = md; stb = s; clr_n = cl; din = d;
      sel  = f_sel(a, b);
      open = md ? sel : s;
      if (open)     m_q = d;
      else if (!cl) m_q = '0;
      if (sel || !cl)        m_srq = 1'b0;
      else if (m_stb && !s)  m_srq = 1'b1;
      m_stb = s;
      repeat (4) @(posedge clk);   // R10: 2 sync stages + latch/flag register
      @(negedge clk);
      chk_bus(req);
      chk_irq(req);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5107_ab12));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R9: idle after reset
      chk_bus("R9"); chk_irq("R9");
      step(1, 0, 1, 0, 1, 8'h00, "R9");           // mode 1 exposes the zero latch

      // R1, R2, R4: select opens latch in mode 1
      step(0, 1, 1, 0, 1, 8'hA5, "R4");
      step(0, 1, 1, 0, 1, 8'h3C, "R4");
      step(0, 0, 1, 0, 1, 8'hFF, "R4");           // closes together with data change
      step(1, 0, 1, 0, 1, 8'h00, "R4");
      step(1, 1, 1, 0, 1, 8'h11, "R1");

      // R5: clear while closed, ignored while open
      step(1, 0, 1, 0, 0, 8'h22, "R5");
      step(1, 0, 1, 0, 1, 8'h22, "R5");
      step(0, 1, 1, 0, 0, 8'h77, "R5");
      step(0, 1, 1, 0, 1, 8'h78, "R5");
      step(1, 0, 1, 0, 1, 8'h00, "R5");

      // R1, R3: mode 0 enable follows select
      step(1, 1, 0, 0, 1, 8'h00, "R1");
      step(0, 0, 0, 0, 1, 8'h00, "R1");
      step(0, 1, 0, 0, 1, 8'h00, "R3");
      step(0, 1, 0, 1, 1, 8'h5A, "R3");           // strobe opens latch, selected -> no request
      step(0, 1, 0, 0, 1, 8'h00, "R3");
      step(1, 0, 0, 0, 1, 8'h00, "R3");

      // R6: rising sets nothing, falling raises request
      step(1, 0, 0, 1, 1, 8'hC3, "R6");
      step(1, 0, 0, 0, 1, 8'h00, "R6");
      step(1, 0, 0, 0, 1, 8'h00, "R8");
      // R7: select clears, clear clears, priority over same fall
      step(0, 1, 0, 0, 1, 8'h00, "R7");
      step(1, 0, 0, 0, 1, 8'h00, "R7");
      step(1, 0, 0, 1, 1, 8'h01, "R7");
      step(1, 0, 0, 0, 1, 8'h00, "R6");
      step(1, 0, 0, 0, 0, 8'h00, "R7");
      step(1, 0, 0, 1, 1, 8'h02, "R7");
      step(0, 1, 0, 0, 1, 8'h00, "R7");           // fall coincides with select
      step(1, 0, 0, 0, 1, 8'h00, "R7");
      step(1, 0, 0, 1, 1, 8'h03, "R7");
      step(1, 0, 0, 0, 0, 8'h00, "R7");           // fall coincides with clear
      step(1, 0, 0, 0, 1, 8'h00, "R7");

      // Random mix: R2, R3, R4, R5, R6, R7, R8
      for (int i = 0; i < 400; i++) begin
         logic [2:0] r;
         r = 3'($urandom_range(0, 7));
         step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              (r != 3'd0), 8'($urandom_range(0, 255)), "R8");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule